// File: doc/BRIEF.md
# Task-File I/O Decoder

This block sits behind the host interface of a removable storage card that is addressed as one contiguous block of sixteen I/O locations. Each host access arrives as a register-space select, four address bits, two active-low byte-lane enables, separate active-low read and write strobes and a 16-bit data bus. The decoder classifies the access and sends it to one of the task-file registers (error/feature, sector count, sector number, cylinder low and high, drive/head, status/command, alternate status/device control, drive address) or to the sector data port.

The data port is reachable at three offsets. Both lanes enabled means a 16-bit word move. A single lane means a byte move that a small phase tracker steers to the even or odd half of the current buffer word. The tracker lets mixed byte and word traffic walk the buffer in order. It also accepts the odd byte before the even byte, and it flags a repeated odd-byte access as a protocol error. The buffer sits behind a word-wide port that has a word pointer, byte enables and a write pulse. All state changes when a strobe is released, and the strobes are sampled on the block clock.

Top module: `tf_io_decoder`

## Requirements
- R1: An access with `reg_n` high, or with both lane enables high, has no effect: `host_rdata` stays 0, the pointer holds, and no register or buffer word is written. `host_rdata` is also 0 whenever `rd_n` is high.
- R2: With both lanes enabled, offsets 0, 8 and 9 move a whole word. A read returns the buffer word at the pointer, a write stores all 16 bits, and each access moves the pointer up by one and clears the byte phase.
- R3: Single-lane byte accesses at offset 0 (low lane only) or at offset 8 give the even byte (bits 7:0 of the word) and then the odd byte (bits 15:8). The pointer moves up after the odd byte.
- R4: Alternating byte accesses to offset 8 and then offset 9 walk the bytes even first, and the pointer moves up after each offset-9 access.
- R5: A byte access to offset 9 followed by one to offset 8 moves the odd byte and then the even byte of the same word, and the pointer moves up after the offset-8 access.
- R6: A byte access to offset 9 after an offset-9 access has already taken the odd byte of the current word returns that odd byte again. It writes nothing, leaves the pointer alone and sets `proto_err`. `proto_err` stays set until reset or a command write.
- R7: Offsets 1 and D, and offset 0 with only the high lane enabled, read `dev_error` and write the feature register.
- R8: Offsets 2 to 6 (sector count, sector number, cylinder low, cylinder high, drive/head) are read/write storage that reset to 0.
- R9: Offset 7 reads `dev_status`. A write to it loads `cmd_code`, pulses `cmd_stb` for one cycle, sets the pointer and phase back to 0 and clears `proto_err`.
- R10: Offset E reads `dev_status` and writes the device-control register. Offset F reads `dev_drive_addr` and ignores writes. Offsets A to C read 0 and ignore writes. None of these offsets moves the pointer.
- R11: State changes only in the clock cycle in which a sampled strobe goes from low to high. Data, address and lanes are taken in that cycle. Byte data uses D7..D0 when `lane_lo_n` is low and D15..D8 otherwise.
- R12: After reset the pointer, phase, `proto_err`, `cmd_stb` and every stored register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_n | input | 1 | Active-low register-space select |
| addr | input | 4 | Offset within the 16-location block |
| lane_lo_n | input | 1 | Active-low enable for D7..D0 |
| lane_hi_n | input | 1 | Active-low enable for D15..D8 |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| host_wdata | input | 16 | Write data from the host |
| host_rdata | output | 16 | Read data to the host, 0 when idle |
| dev_error | input | 8 | Error byte supplied by the device core |
| dev_status | input | 8 | Status byte supplied by the device core |
| dev_drive_addr | input | 8 | Drive address byte supplied by the device core |
| buf_addr | output | 8 | Buffer word pointer |
| buf_rdata | input | 16 | Buffer word at `buf_addr` |
| buf_we | output | 1 | Buffer write pulse for this cycle |
| buf_be | output | 2 | Buffer byte enables (bit 0 even, bit 1 odd) |
| buf_wdata | output | 16 | Buffer write data |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Sector count register |
| tf_sector | output | 8 | Sector number register |
| tf_cyl_lo | output | 8 | Cylinder low register |
| tf_cyl_hi | output | 8 | Cylinder high register |
| tf_drv_head | output | 8 | Drive/head register |
| tf_devctl | output | 8 | Device-control register |
| cmd_code | output | 8 | Last command byte written |
| cmd_stb | output | 1 | One-cycle pulse after a command write |
| proto_err | output | 1 | Sticky flag for a repeated odd-byte access |

## Verification
The bound checker watches several properties on every cycle. The read bus must be 0 whenever no read is selected. The pointer may only step up by one or go back to zero, and it must be 0 while the command strobe is high. It must not move while a strobe is held low. Buffer writes may only happen on a write release with enables set, and the error flag may only fall alongside a command. The byte order the phase tracker produces cannot be judged one cycle at a time. This covers even-then-odd, odd-then-even, the refused repeat of offset 9, and the data a byte write merges into a word. Only the bench scenarios can show these, by comparing returned bytes and buffer contents with a model memory. The same applies to the register aliasing across offsets 0, 1, D, E and F.

// File: rtl/tf_pkg.sv
package tf_pkg;

    // Access classes produced by the address decoder.
    typedef enum logic [3:0] {
        K_NONE,
        K_WORD,
        K_EVEN,
        K_ODD,
        K_ERRFEAT,
        K_COUNT,
        K_SECTOR,
        K_CYLLO,
        K_CYLHI,
        K_DRVHD,
        K_STATCMD,
        K_ALTCTL,
        K_DRVADDR,
        K_RSVD
    } acc_kind_e;

    // Byte phase within the current buffer word.
    typedef enum logic [1:0] {
        PH_EVEN      = 2'd0,  // next single byte is the even one
        PH_ODD       = 2'd1,  // even taken, odd byte completes the word
        PH_ODD_TAKEN = 2'd2   // odd taken first, even byte completes the word
    } phase_e;

    typedef struct packed {
        logic [7:0] feature;
        logic [7:0] count;
        logic [7:0] sector;
        logic [7:0] cyl_lo;
        logic [7:0] cyl_hi;
        logic [7:0] drv_head;
        logic [7:0] devctl;
        logic [7:0] cmd;
    } tf_regs_t;

endpackage

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
    import tf_pkg::*;
(
    input  logic       reg_n,
    input  logic [3:0] addr,
    input  logic       lane_lo_n,
    input  logic       lane_hi_n,
    output acc_kind_e  kind
);

    logic word_acc;

    assign word_acc = !lane_lo_n && !lane_hi_n;

    always_comb begin
        kind = K_NONE;
        if (!reg_n && !(lane_lo_n && lane_hi_n)) begin
            case (addr)
                4'h0:    kind = word_acc ? K_WORD : (!lane_lo_n ? K_EVEN : K_ERRFEAT);
                4'h8:    kind = word_acc ? K_WORD : K_EVEN;
                4'h9:    kind = word_acc ? K_WORD : K_ODD;
                4'h1:    kind = K_ERRFEAT;
                4'hD:    kind = K_ERRFEAT;
                4'h2:    kind = K_COUNT;
                4'h3:    kind = K_SECTOR;
                4'h4:    kind = K_CYLLO;
                4'h5:    kind = K_CYLHI;
                4'h6:    kind = K_DRVHD;
                4'h7:    kind = K_STATCMD;
                4'hE:    kind = K_ALTCTL;
                4'hF:    kind = K_DRVADDR;
                default: kind = K_RSVD;
            endcase
        end
    end

endmodule

// File: rtl/tf_strobe_edge.sv
module tf_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] rise
);

    for (genvar g = 0; g < N; g++) begin : g_edge
        logic level_q;

        always_ff @(posedge clk) begin
            if (!rst_n) level_q <= 1'b1;
            else        level_q <= strobe_n[g];
        end

        assign rise[g] = strobe_n[g] && !level_q;
    end

endmodule

// File: rtl/tf_read_mux.sv
module tf_read_mux
    import tf_pkg::*;
(
    input  acc_kind_e   kind,
    input  logic        rd_n,
    input  phase_e      phase,
    input  logic        lane_lo_n,
    input  logic [15:0] buf_rdata,
    input  logic [7:0]  count,
    input  logic [7:0]  sector,
    input  logic [7:0]  cyl_lo,
    input  logic [7:0]  cyl_hi,
    input  logic [7:0]  drv_head,
    input  logic [7:0]  dev_error,
    input  logic [7:0]  dev_status,
    input  logic [7:0]  dev_drive_addr,
    output logic [15:0] host_rdata
);

    logic [7:0] byte_val;

    always_comb begin
        case (kind)
            K_EVEN:    byte_val = (phase == PH_ODD) ? buf_rdata[15:8] : buf_rdata[7:0];
            K_ODD:     byte_val = buf_rdata[15:8];
            K_ERRFEAT: byte_val = dev_error;
            K_COUNT:   byte_val = count;
            K_SECTOR:  byte_val = sector;
            K_CYLLO:   byte_val = cyl_lo;
            K_CYLHI:   byte_val = cyl_hi;
            K_DRVHD:   byte_val = drv_head;
            K_STATCMD: byte_val = dev_status;
            K_ALTCTL:  byte_val = dev_status;
            K_DRVADDR: byte_val = dev_drive_addr;
            default:   byte_val = 8'h00;
        endcase

        if (rd_n || kind == K_NONE) host_rdata = 16'h0000;
        else if (kind == K_WORD)    host_rdata = buf_rdata;
        else if (lane_lo_n)         host_rdata = {byte_val, 8'h00};
        else                        host_rdata = {8'h00, byte_val};
    end

endmodule

// File: rtl/tf_io_decoder.sv
module tf_io_decoder
    import tf_pkg::*;
#(
    parameter int BUF_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_n,
    input  logic [3:0]  addr,
    input  logic        lane_lo_n,
    input  logic        lane_hi_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic [7:0]  dev_error,
    input  logic [7:0]  dev_status,
    input  logic [7:0]  dev_drive_addr,
    output logic [7:0]  buf_addr,
    input  logic [15:0] buf_rdata,
    output logic        buf_we,
    output logic [1:0]  buf_be,
    output logic [15:0] buf_wdata,
    output logic [7:0]  tf_feature,
    output logic [7:0]  tf_count,
    output logic [7:0]  tf_sector,
    output logic [7:0]  tf_cyl_lo,
    output logic [7:0]  tf_cyl_hi,
    output logic [7:0]  tf_drv_head,
    output logic [7:0]  tf_devctl,
    output logic [7:0]  cmd_code,
    output logic        cmd_stb,
    output logic        proto_err
);

    localparam int PTR_W = $clog2(BUF_WORDS);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        phase_e           phase;
        logic             err;
        logic             cmd_stb;
        tf_regs_t         regs;
    } state_t;

    state_t    st_d, st_q;
    acc_kind_e kind;
    logic [1:0] rise;
    logic       rd_ev, wr_ev;
    logic [7:0] wbyte;
    logic       buf_we_d;
    logic [1:0] buf_be_d;
    logic [15:0] buf_wdata_d;

    tf_addr_decode i_decode (
        .reg_n     (reg_n),
        .addr      (addr),
        .lane_lo_n (lane_lo_n),
        .lane_hi_n (lane_hi_n),
        .kind      (kind)
    );

    tf_strobe_edge #(.N(2)) i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({wr_n, rd_n}),
        .rise     (rise)
    );

    tf_read_mux i_rmux (
        .kind           (kind),
        .rd_n           (rd_n),
        .phase          (st_q.phase),
        .lane_lo_n      (lane_lo_n),
        .buf_rdata      (buf_rdata),
        .count          (st_q.regs.count),
        .sector         (st_q.regs.sector),
        .cyl_lo         (st_q.regs.cyl_lo),
        .cyl_hi         (st_q.regs.cyl_hi),
        .drv_head       (st_q.regs.drv_head),
        .dev_error      (dev_error),
        .dev_status     (dev_status),
        .dev_drive_addr (dev_drive_addr),
        .host_rdata     (host_rdata)
    );

    // A write release takes precedence if both strobes release together.
    assign wr_ev = rise[1];
    assign rd_ev = rise[0] && !rise[1];
    assign wbyte = lane_lo_n ? host_wdata[15:8] : host_wdata[7:0];

    always_comb begin
        st_d         = st_q;
        st_d.cmd_stb = 1'b0;
        buf_we_d     = 1'b0;
        buf_be_d     = 2'b00;
        buf_wdata_d  = 16'h0000;

        if (rd_ev || wr_ev) begin
            case (kind)
                K_WORD: begin
                    st_d.ptr   = st_q.ptr + PTR_ONE;
                    st_d.phase = PH_EVEN;
                    buf_we_d   = wr_ev;
                    buf_be_d   = 2'b11;
                    buf_wdata_d = host_wdata;
                end
                K_EVEN: begin
                    buf_wdata_d = {wbyte, wbyte};
                    case (st_q.phase)
                        PH_ODD: begin
                            st_d.phase = PH_EVEN;
                            st_d.ptr   = st_q.ptr + PTR_ONE;
                            buf_be_d   = 2'b10;
                        end
                        PH_ODD_TAKEN: begin
                            st_d.phase = PH_EVEN;
                            st_d.ptr   = st_q.ptr + PTR_ONE;
                            buf_be_d   = 2'b01;
                        end
                        default: begin
                            st_d.phase = PH_ODD;
                            buf_be_d   = 2'b01;
                        end
                    endcase
                    buf_we_d = wr_ev;
                end
                K_ODD: begin
                    buf_wdata_d = {wbyte, wbyte};
                    buf_be_d    = 2'b10;
                    case (st_q.phase)
                        PH_ODD: begin
                            st_d.phase = PH_EVEN;
                            st_d.ptr   = st_q.ptr + PTR_ONE;
                            buf_we_d   = wr_ev;
                        end
                        PH_ODD_TAKEN: begin
                            st_d.err = 1'b1;
                            buf_be_d = 2'b00;
                        end
                        default: begin
                            st_d.phase = PH_ODD_TAKEN;
                            buf_we_d   = wr_ev;
                        end
                    endcase
                end
                default: begin
                    if (wr_ev) begin
                        case (kind)
                            K_ERRFEAT: st_d.regs.feature  = wbyte;
                            K_COUNT:   st_d.regs.count    = wbyte;
                            K_SECTOR:  st_d.regs.sector   = wbyte;
                            K_CYLLO:   st_d.regs.cyl_lo   = wbyte;
                            K_CYLHI:   st_d.regs.cyl_hi   = wbyte;
                            K_DRVHD:   st_d.regs.drv_head = wbyte;
                            K_ALTCTL:  st_d.regs.devctl   = wbyte;
                            K_STATCMD: begin
                                st_d.regs.cmd = wbyte;
                                st_d.cmd_stb  = 1'b1;
                                st_d.ptr      = '0;
                                st_d.phase    = PH_EVEN;
                                st_d.err      = 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_addr    = 8'(st_q.ptr);
    assign buf_we      = buf_we_d;
    assign buf_be      = buf_be_d;
    assign buf_wdata   = buf_wdata_d;
    assign tf_feature  = st_q.regs.feature;
    assign tf_count    = st_q.regs.count;
    assign tf_sector   = st_q.regs.sector;
    assign tf_cyl_lo   = st_q.regs.cyl_lo;
    assign tf_cyl_hi   = st_q.regs.cyl_hi;
    assign tf_drv_head = st_q.regs.drv_head;
    assign tf_devctl   = st_q.regs.devctl;
    assign cmd_code    = st_q.regs.cmd;
    assign cmd_stb     = st_q.cmd_stb;
    assign proto_err   = st_q.err;

endmodule

// File: rtl/tf_io_decoder_chk.sv
module tf_io_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic [15:0] host_rdata,
    input logic [7:0]  buf_addr,
    input logic        buf_we,
    input logic [1:0]  buf_be,
    input logic        cmd_stb,
    input logic        proto_err
);

    // R1: nothing on the read bus unless a selected read is in progress
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_n || rd_n) |-> host_rdata == 16'h0000);

    // R2: pointer only steps by one or rewinds to zero
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_addr != $past(buf_addr)) |-> (buf_addr == $past(buf_addr) + 8'd1 || buf_addr == 8'd0));

    // R2: a buffer write always carries at least one byte enable
    p_be_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> buf_be != 2'b00);

    // R6: the protocol error flag falls only together with a command
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(proto_err) && !cmd_stb) |-> proto_err);

    // R9: a command leaves the pointer at word zero
    p_cmd_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> buf_addr == 8'd0);

    // R11: the pointer holds while a strobe stays low
    p_hold_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n && $past(!rd_n)) || (!wr_n && $past(!wr_n))) |=> $stable(buf_addr));

    // R11: buffer writes only on a released write strobe inside register space
    p_we_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (wr_n && !reg_n));

endmodule

bind tf_io_decoder tf_io_decoder_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_n      (reg_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .host_rdata (host_rdata),
    .buf_addr   (buf_addr),
    .buf_we     (buf_we),
    .buf_be     (buf_be),
    .cmd_stb    (cmd_stb),
    .proto_err  (proto_err)
);

// File: tb/test_tf_io_decoder.sv
module test_tf_io_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_n = 1'b1;
    logic [3:0]  addr = 4'h0;
    logic        lane_lo_n = 1'b1;
    logic        lane_hi_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic [7:0]  dev_error = 8'h04;
    logic [7:0]  dev_status = 8'h50;
    logic [7:0]  dev_drive_addr = 8'hE1;
    logic [7:0]  buf_addr;
    logic [15:0] buf_rdata;
    logic        buf_we;
    logic [1:0]  buf_be;
    logic [15:0] buf_wdata;
    logic [7:0]  tf_feature, tf_count, tf_sector, tf_cyl_lo, tf_cyl_hi;
    logic [7:0]  tf_drv_head, tf_devctl, cmd_code;
    logic        cmd_stb, proto_err;

    int checks = 0;
    int failures = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tf_io_decoder i_tf_io_decoder (
        .clk(clk), .rst_n(rst_n), .reg_n(reg_n), .addr(addr),
        .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .rd_n(rd_n), .wr_n(wr_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_error(dev_error), .dev_status(dev_status), .dev_drive_addr(dev_drive_addr),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_be(buf_be),
        .buf_wdata(buf_wdata), .tf_feature(tf_feature), .tf_count(tf_count),
        .tf_sector(tf_sector), .tf_cyl_lo(tf_cyl_lo), .tf_cyl_hi(tf_cyl_hi),
        .tf_drv_head(tf_drv_head), .tf_devctl(tf_devctl), .cmd_code(cmd_code),
        .cmd_stb(cmd_stb), .proto_err(proto_err)
    );

    // Model buffer: word i holds {i+8'h10, i} after reset.
    logic [15:0] mem [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= {8'(i + 16), 8'(i)};
        end else if (buf_we) begin
            if (buf_be[0]) mem[buf_addr][7:0]  <= buf_wdata[7:0];
            if (buf_be[1]) mem[buf_addr][15:8] <= buf_wdata[15:8];
        end
    end
    assign buf_rdata = mem[buf_addr];

    always @(negedge clk) if (rst_n && cmd_stb) stb_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io(input logic rn, input logic wr, input logic [3:0] a,
                      input logic lo, input logic hi, input logic [15:0] d,
                      input int hold, output logic [15:0] rv, output logic [7:0] am);
        @(negedge clk);
        reg_n = rn; addr = a; lane_lo_n = lo; lane_hi_n = hi; host_wdata = d;
        @(negedge clk);
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        rv = host_rdata;
        am = buf_addr;
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        reg_n = 1'b1; lane_lo_n = 1'b1; lane_hi_n = 1'b1;
    endtask

    typedef struct packed {
        logic        wr;
        logic [3:0]  a;
        logic        lo_n;
        logic        hi_n;
        logic [15:0] d;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'h0, 1'b0, 1'b0, 16'h0000, 16'h1000, 8'd2},   // R2 word at 0
        '{1'b0, 4'h8, 1'b0, 1'b0, 16'h0000, 16'h1101, 8'd2},   // R2 word at 8
        '{1'b0, 4'h9, 1'b0, 1'b0, 16'h0000, 16'h1202, 8'd2},   // R2 word at 9
        '{1'b0, 4'h0, 1'b0, 1'b1, 16'h0000, 16'h0003, 8'd3},   // R3 even byte at 0
        '{1'b0, 4'h0, 1'b0, 1'b1, 16'h0000, 16'h0013, 8'd3},   // R3 odd byte at 0
        '{1'b0, 4'h8, 1'b0, 1'b1, 16'h0000, 16'h0004, 8'd4},   // R4 even at 8
        '{1'b0, 4'h9, 1'b0, 1'b1, 16'h0000, 16'h0014, 8'd4},   // R4 odd at 9
        '{1'b0, 4'h9, 1'b0, 1'b1, 16'h0000, 16'h0015, 8'd5},   // R5 odd first
        '{1'b0, 4'h8, 1'b0, 1'b1, 16'h0000, 16'h0005, 8'd5},   // R5 even second
        '{1'b0, 4'h8, 1'b1, 1'b0, 16'h0000, 16'h0600, 8'd11},  // R11 high lane byte
        '{1'b0, 4'h8, 1'b0, 1'b1, 16'h0000, 16'h0016, 8'd3},   // R3 odd at 8
        '{1'b1, 4'h2, 1'b0, 1'b1, 16'h00A5, 16'h0000, 8'd8},   // R8 write count
        '{1'b0, 4'h2, 1'b0, 1'b1, 16'h0000, 16'h00A5, 8'd8},   // R8 read count
        '{1'b1, 4'h6, 1'b1, 1'b0, 16'h3C00, 16'h0000, 8'd8},   // R8 drive/head via high lane
        '{1'b0, 4'h6, 1'b0, 1'b1, 16'h0000, 16'h003C, 8'd8},   // R8 read drive/head
        '{1'b0, 4'h7, 1'b0, 1'b1, 16'h0000, 16'h0050, 8'd9},   // R9 status
        '{1'b0, 4'hE, 1'b1, 1'b0, 16'h0000, 16'h5000, 8'd10},  // R10 alt status
        '{1'b0, 4'h1, 1'b0, 1'b1, 16'h0000, 16'h0004, 8'd7},   // R7 error at 1
        '{1'b0, 4'h0, 1'b1, 1'b0, 16'h0000, 16'h0400, 8'd7},   // R7 error at 0 high lane
        '{1'b0, 4'hD, 1'b0, 1'b1, 16'h0000, 16'h0004, 8'd7},   // R7 error at D
        '{1'b1, 4'hF, 1'b0, 1'b1, 16'h0077, 16'h0000, 8'd10},  // R10 write F ignored
        '{1'b0, 4'hF, 1'b0, 1'b1, 16'h0000, 16'h00E1, 8'd10},  // R10 drive address
        '{1'b0, 4'hA, 1'b0, 1'b1, 16'h0000, 16'h0000, 8'd10},  // R10 reserved reads 0
        '{1'b0, 4'h3, 1'b0, 1'b0, 16'h0000, 16'h0000, 8'd8}    // R8 sector resets to 0
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        logic [7:0]  am;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 pointer", buf_addr, 0);
        chk("R12 read bus", host_rdata, 0);
        chk("R12 proto_err", proto_err, 0);
        chk("R12 registers", {tf_feature, tf_count, tf_sector, tf_cyl_lo}, 0);
        chk("R12 registers hi", {tf_cyl_hi, tf_drv_head, tf_devctl, cmd_code}, 0);

        for (int i = 0; i < NV; i++) begin
            io(1'b0, VEC[i].wr, VEC[i].a, VEC[i].lo_n, VEC[i].hi_n, VEC[i].d, 2, rv, am);
            if (!VEC[i].wr)
                chk($sformatf("R%0d vector %0d", VEC[i].req, i), rv, VEC[i].exp);
        end

        // R10: register traffic left the pointer at word 7
        chk("R10 pointer untouched by registers", buf_addr, 7);

        // R6: repeated odd-byte access
        io(1'b0, 1'b0, 4'h9, 1'b0, 1'b1, 16'h0, 2, rv, am);
        chk("R6 first odd", rv, 16'h0017);
        chk("R6 no flag yet", proto_err, 0);
        io(1'b0, 1'b0, 4'h9, 1'b0, 1'b1, 16'h0, 2, rv, am);
        chk("R6 repeated odd data", rv, 16'h0017);
        chk("R6 flag set", proto_err, 1);
        chk("R6 pointer held", buf_addr, 7);
        io(1'b0, 1'b1, 4'h9, 1'b0, 1'b1, 16'h0099, 2, rv, am);
        chk("R6 repeated odd write dropped", mem[7], 16'h1707);
        io(1'b0, 1'b0, 4'h8, 1'b0, 1'b1, 16'h0, 2, rv, am);
        chk("R5 even completes word", rv, 16'h0007);
        chk("R5 pointer advanced", buf_addr, 8);
        chk("R6 flag sticky", proto_err, 1);

        // R7 feature writes
        io(1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 16'h5A00, 2, rv, am);
        chk("R7 feature via offset 0 high lane", tf_feature, 8'h5A);
        io(1'b0, 1'b1, 4'hD, 1'b0, 1'b1, 16'h0033, 2, rv, am);
        chk("R7 feature via offset D", tf_feature, 8'h33);

        // R9 command write
        io(1'b0, 1'b1, 4'h7, 1'b0, 1'b1, 16'h0020, 2, rv, am);
        @(negedge clk);
        chk("R9 strobe count", stb_cnt, 1);
        chk("R9 command code", cmd_code, 8'h20);
        chk("R9 pointer rewound", buf_addr, 0);
        chk("R9 flag cleared", proto_err, 0);

        // R3/R4/R5 byte writes and R2 word write
        io(1'b0, 1'b1, 4'h8, 1'b0, 1'b1, 16'h00AA, 2, rv, am);
        io(1'b0, 1'b1, 4'h9, 1'b0, 1'b1, 16'h00BB, 2, rv, am);
        chk("R4 byte writes merge", mem[0], 16'hBBAA);
        chk("R4 pointer after pair", buf_addr, 1);
        io(1'b0, 1'b1, 4'h9, 1'b0, 1'b1, 16'h00CC, 2, rv, am);
        io(1'b0, 1'b1, 4'h8, 1'b0, 1'b1, 16'h00DD, 2, rv, am);
        chk("R5 odd-then-even write", mem[1], 16'hCCDD);
        io(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 16'hBEEF, 2, rv, am);
        chk("R2 word write", mem[2], 16'hBEEF);
        chk("R2 pointer after word write", buf_addr, 3);

        // R11: long strobe, state moves only after release
        io(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 16'h0, 6, rv, am);
        chk("R11 data during long strobe", rv, 16'h1303);
        chk("R11 pointer held while low", am, 3);
        chk("R11 pointer after release", buf_addr, 4);

        // R1: deselected or laneless accesses have no effect
        io(1'b1, 1'b0, 4'h8, 1'b0, 1'b0, 16'h0, 2, rv, am);
        chk("R1 deselected read bus", rv, 0);
        io(1'b1, 1'b1, 4'h2, 1'b0, 1'b1, 16'h0011, 2, rv, am);
        chk("R1 deselected write", tf_count, 8'hA5);
        io(1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 16'h0, 2, rv, am);
        chk("R1 no-lane read bus", rv, 0);
        io(1'b0, 1'b1, 4'h0, 1'b1, 1'b1, 16'h1234, 2, rv, am);
        chk("R1 no-lane write buffer", mem[4], 16'h1404);
        chk("R1 pointer unchanged", buf_addr, 4);

        // R10 device control
        io(1'b0, 1'b1, 4'hE, 1'b0, 1'b1, 16'h0006, 2, rv, am);
        chk("R10 device control", tf_devctl, 8'h06);
        chk("R10 pointer unchanged", buf_addr, 4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule